// File: doc/BRIEF.md
# Linear Frequency Sweep Accumulator

This block produces a time-varying tuning word for a direct digital synthesizer. The main phase accumulator normally adds a fixed increment. Here that increment comes from an auxiliary accumulator, which adds or subtracts a programmed delta at a rate set by a clock divider. The synthesized frequency therefore ramps linearly. The same word can drive a phase or amplitude path instead, because the block only produces a ramping number.

A start pulse loads the sweep origin and restarts the rate divider. The origin is the lower limit when sweeping up and the upper limit when sweeping down. From then on, the accumulator moves by one delta every K clock cycles. When the next step would reach or pass the far limit, the output is clamped to that limit and does not wrap. The done flag is then raised, and the value holds until the next start.

Top module: `lin_sweep_acc`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `ftw_o` is 0 and `done_o` is 0.
- R2: A cycle with `start_i` high loads `ftw_o` at that edge. It loads `lo_lim_i` when `dir_i`=0 (up) and `hi_lim_i` when `dir_i`=1 (down), and it clears `done_o`.
- R3: After a start edge, steps occur on the K-th edge after it and on every K-th edge after that. K is `rate_div_i`, and a value of 0 acts as 1. On other cycles `ftw_o` does not change.
- R4: In an upward sweep, each step adds `delta_i` (zero-extended) to `ftw_o`.
- R5: In a downward sweep, each step subtracts `delta_i` from `ftw_o`.
- R6: In an upward sweep, a step whose sum would reach or exceed `hi_lim_i` sets `ftw_o` to `hi_lim_i` and raises `done_o`. This holds even when the sum would overflow the accumulator width.
- R7: In a downward sweep, a step whose result would reach or fall below `lo_lim_i` sets `ftw_o` to `lo_lim_i` and raises `done_o`. This holds even when the subtraction would underflow.
- R8: Once `done_o` is high, `ftw_o` and `done_o` hold until the next start, whatever `delta_i` does.
- R9: A start during a running sweep abandons it, reloads the origin and restarts the step timing.
- R10: The direction is captured at start. Changing `dir_i` during a sweep has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load origin and begin sweep |
| dir_i | input | 1 | 0 sweeps up, 1 sweeps down |
| delta_i | input | DELTA_W | Step size |
| rate_div_i | input | DIV_W | Cycles per step K (0 treated as 1) |
| lo_lim_i | input | ACC_W | Lower frequency limit |
| hi_lim_i | input | ACC_W | Upper frequency limit |
| ftw_o | output | ACC_W | Instantaneous tuning word |
| done_o | output | 1 | Sweep reached its far limit |

## Verification
The loaded origin is visible one edge after the start cycle. The n-th step, and with it any clamp and the rise of done, is due exactly n·K edges after the start edge. The bench drives inputs on falling edges and checks every cycle on a falling edge. It counts c edges from the start edge and compares the outputs against a closed-form value built from floor(c/K) steps. Every cycle between steps is therefore checked as well, which proves the hold behaviour.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic {
    SWEEP_UP   = 1'b0,
    SWEEP_DOWN = 1'b1
  } sweep_dir_e;
endpackage

// File: rtl/sweep_rate_div.sv
module sweep_rate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] reload;

  // K=0 behaves as K=1
  assign reload = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = run_i && !restart_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= reload;
    else if (run_i) begin
      if (cnt_q == '0)  cnt_q <= reload;
      else              cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sweep_step.sv
module sweep_step #(
  parameter int ACC_W   = 16,
  parameter int DELTA_W = 8
) (
  input  sweep_pkg::sweep_dir_e dir_i,
  input  logic [ACC_W-1:0]      acc_i,
  input  logic [DELTA_W-1:0]    delta_i,
  input  logic [ACC_W-1:0]      lo_i,
  input  logic [ACC_W-1:0]      hi_i,
  output logic [ACC_W-1:0]      next_o,
  output logic                  hit_o
);
  localparam int WW = ACC_W + 1;

  logic [WW-1:0] d_w, sum_w, floor_w;

  // one spare bit so limit compares never see wraparound
  assign d_w     = {{(WW-DELTA_W){1'b0}}, delta_i};
  assign sum_w   = {1'b0, acc_i} + d_w;
  assign floor_w = {1'b0, lo_i} + d_w;

  always_comb begin
    if (dir_i == sweep_pkg::SWEEP_UP) begin
      hit_o  = sum_w >= {1'b0, hi_i};
      next_o = hit_o ? hi_i : sum_w[ACC_W-1:0];
    end else begin
      hit_o  = {1'b0, acc_i} <= floor_w;
      next_o = hit_o ? lo_i : acc_i - d_w[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/lin_sweep_acc.sv
module lin_sweep_acc #(
  parameter int ACC_W   = 16,
  parameter int DELTA_W = 8,
  parameter int DIV_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               dir_i,
  input  logic [DELTA_W-1:0] delta_i,
  input  logic [DIV_W-1:0]   rate_div_i,
  input  logic [ACC_W-1:0]   lo_lim_i,
  input  logic [ACC_W-1:0]   hi_lim_i,
  output logic [ACC_W-1:0]   ftw_o,
  output logic               done_o
);
  import sweep_pkg::*;

  logic [ACC_W-1:0] acc_q, acc_next;
  logic             run_q, done_q, step_en, hit;
  sweep_dir_e       dir_q;

  sweep_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(start_i),
    .run_i    (run_q),
    .div_i    (rate_div_i),
    .tick_o   (step_en)
  );

  sweep_step #(.ACC_W(ACC_W), .DELTA_W(DELTA_W)) u_step (
    .dir_i  (dir_q),
    .acc_i  (acc_q),
    .delta_i(delta_i),
    .lo_i   (lo_lim_i),
    .hi_i   (hi_lim_i),
    .next_o (acc_next),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      dir_q  <= SWEEP_UP;
    end else if (start_i) begin
      acc_q  <= dir_i ? hi_lim_i : lo_lim_i;
      dir_q  <= sweep_dir_e'(dir_i);
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (step_en) begin
      acc_q <= acc_next;
      if (hit) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign ftw_o  = acc_q;
  assign done_o = done_q;
endmodule

// File: rtl/lin_sweep_acc_chk.sv
module lin_sweep_acc_chk #(
  parameter int ACC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             dir_i,
  input logic [ACC_W-1:0] lo_lim_i,
  input logic [ACC_W-1:0] hi_lim_i,
  input logic [ACC_W-1:0] ftw_o,
  input logic             done_o,
  input logic             step_en,
  input logic             dir_q
);
  // R2
  start_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
  // R2
  up_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !dir_i) |=> ftw_o == $past(lo_lim_i));
  // R2
  down_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && dir_i) |=> ftw_o == $past(hi_lim_i));
  // R3
  no_step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !step_en) |=> $stable(ftw_o));
  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> ($stable(ftw_o) && done_o));
  // R6
  up_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && !dir_q) |-> ftw_o == hi_lim_i);
  // R7
  down_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && dir_q) |-> ftw_o == lo_lim_i);
endmodule

bind lin_sweep_acc lin_sweep_acc_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .dir_i   (dir_i),
  .lo_lim_i(lo_lim_i),
  .hi_lim_i(hi_lim_i),
  .ftw_o   (ftw_o),
  .done_o  (done_o),
  .step_en (step_en),
  .dir_q   (dir_q)
);

// File: tb/lin_sweep_acc_bench.sv
`timescale 1ns/1ps
module lin_sweep_acc_bench;
  localparam int ACC_W = 16, DELTA_W = 8, DIV_W = 8;
  localparam int NVEC = 5, NCYC = 60;
  // dir, lo, hi, delta, K
  localparam int VEC [NVEC][5] = '{
    '{0,   100,   130,  10, 3},
    '{1,  1000,  1500,   7, 1},
    '{0,     0, 65535, 255, 0},
    '{0, 65000, 65535, 200, 2},
    '{1,     0,    50,  20, 2}
  };

  logic clk_i = 0, rst_ni = 0, start_i = 0, dir_i = 0;
  logic [DELTA_W-1:0] delta_i = '0;
  logic [DIV_W-1:0]   rate_div_i = '0;
  logic [ACC_W-1:0]   lo_lim_i = '0, hi_lim_i = '0, ftw_o;
  logic               done_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  lin_sweep_acc #(.ACC_W(ACC_W), .DELTA_W(DELTA_W), .DIV_W(DIV_W)) u_lin_sweep_acc (
    .clk_i, .rst_ni, .start_i, .dir_i, .delta_i, .rate_div_i,
    .lo_lim_i, .hi_lim_i, .ftw_o, .done_o
  );

  task automatic chk(string req, longint act_f, longint exp_f, bit act_d, bit exp_d);
    total++;
    if (act_f != exp_f || act_d != exp_d) begin
      bad++;
      $display("FAIL %s: ftw=%0d done=%0d expected ftw=%0d done=%0d",
               req, act_f, act_d, exp_f, exp_d);
    end
  endtask

  // closed-form expectation c edges after the start edge
  task automatic expect_at(int dir, int lo, int hi, int d, int k, int c,
                           output longint ef, output bit ed);
    int kk = (k == 0) ? 1 : k;
    longint s = c / kk;
    longint v;
    if (dir == 0) begin
      v = lo + s * d;
      ed = (s > 0) && (v >= hi);
      ef = ed ? hi : v;
    end else begin
      v = hi - s * d;
      ed = (s > 0) && (v <= lo);
      ef = ed ? lo : v;
    end
  endtask

  task automatic begin_sweep(int dir, int lo, int hi, int d, int k);
    @(negedge clk_i);
    dir_i = dir[0]; lo_lim_i = lo[ACC_W-1:0]; hi_lim_i = hi[ACC_W-1:0];
    delta_i = d[DELTA_W-1:0]; rate_div_i = k[DIV_W-1:0]; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    dir_i = ~dir[0]; // R10: must not affect running sweep
  endtask

  initial begin
    #(20.0 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: ftw=%0d done=%0d expected completion", ftw_o, done_o);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint ef; bit ed;
    #35;
    chk("R1 in reset", ftw_o, 0, done_o, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk_i);
    chk("R1 after reset", ftw_o, 0, done_o, 0);

    for (int v = 0; v < NVEC; v++) begin
      begin_sweep(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      for (int c = 0; c < NCYC; c++) begin
        if (c > 0) @(negedge clk_i);
        expect_at(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], c, ef, ed);
        if (c == 0)                       chk("R2 origin", ftw_o, ef, done_o, ed);
        else if (ed && VEC[v][0] == 0)    chk("R6 up clamp/R10", ftw_o, ef, done_o, ed);
        else if (ed)                      chk("R7 down clamp/R10", ftw_o, ef, done_o, ed);
        else if (VEC[v][0] == 0)          chk("R3 R4 up step/R10", ftw_o, ef, done_o, ed);
        else                              chk("R3 R5 down step/R10", ftw_o, ef, done_o, ed);
      end
    end

    // R8: finished sweep ignores delta changes
    begin_sweep(0, 100, 130, 10, 3);
    repeat (12) @(negedge clk_i);
    chk("R8 done reached", ftw_o, 130, done_o, 1);
    delta_i = 8'd1;
    repeat (5) @(negedge clk_i);
    chk("R8 hold after delta change", ftw_o, 130, done_o, 1);
    delta_i = 8'd200;
    repeat (5) @(negedge clk_i);
    chk("R8 hold after second delta change", ftw_o, 130, done_o, 1);

    // R9: restart mid-sweep
    begin_sweep(0, 100, 130, 10, 3);
    repeat (4) @(negedge clk_i);
    chk("R9 mid-sweep value", ftw_o, 110, done_o, 0);
    begin_sweep(0, 500, 600, 1, 1);
    chk("R9 restart origin", ftw_o, 500, done_o, 0);
    @(negedge clk_i);
    chk("R9 restart first step", ftw_o, 501, done_o, 0);

    // R2: start clears done (down origin)
    begin_sweep(1, 10, 20, 5, 1);
    chk("R2 down origin", ftw_o, 20, done_o, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule